// File: doc/BRIEF.md
# ADC scan sequencer

This block is the byte-wide register front end of a sixteen-input multiplexed 12-bit converter. Software programs a channel window (first and last channel) and one gain code per channel. It then picks a trigger source: software, an external pulse or a pacer tick. Each accepted trigger converts the current channel with that channel's stored gain. The next-channel pointer then moves one step through the window, wrapping back to the first channel after the last one.

The converter itself sits outside the block. It receives a one-cycle start pulse together with the channel and gain, and it answers with a done pulse and the sample. The block packs the sample and the channel number into a 16-bit result word. It then raises end-of-conversion and data-ready. Depending on the control register, it signals completion either through an interrupt level or through a one-cycle DMA request.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control register reads 0x00, irq and dma_req are low, and status (offset 8) reads {eoc=0, uni_mode, se_mode, ready=0, next channel=0}. Status bit 7 is end-of-conversion, bit 6 is the uni_mode pin, bit 5 is the se_mode pin, bit 4 is data-ready and bits 3:0 are the next channel.
- R2: A write to offset 2 stores the first channel from bits 3:0 and the last channel from bits 7:4. It loads the next channel with the first channel. Offset 2 reads back the byte that was written.
- R3: A write to offset 1 stores a gain code (bits 3:0) for the first channel of the most recent offset-2 write. conv_gain carries the stored gain of the channel being converted.
- R4: Control bits 1:0 select the trigger source: 0 none, 1 any write to offset 0, 2 ext_trig, 3 pacer_tick. The sources that are not selected start no conversion and leave the next channel unchanged.
- R5: An accepted trigger produces a one-cycle conv_start in the following cycle, with conv_chan equal to the channel that status showed as next. The next channel then advances.
- R6: On conv_done the result word {conv_data, channel} is stored. Offset 0 reads bits 7:0 of it and offset 1 reads bits 15:8.
- R7: After the last channel the sequence returns to the first channel. Channel numbers wrap modulo 16 when se_mode=1 and modulo 8 when se_mode=0. For example, window 14..1 visits 14, 15, 0, 1, and window 6..1 in 8-channel mode visits 6, 7, 0, 1.
- R8: When first equals last, every conversion uses that one channel.
- R9: conv_start clears end-of-conversion. conv_done sets both end-of-conversion and data-ready. Any write to offset 8 clears data-ready and the overrun flag but leaves end-of-conversion set.
- R10: irq equals data-ready AND control bit 7 while control bit 2 (DMA) is 0. With bit 2 set, irq stays low and each completion gives exactly one one-cycle dma_req.
- R11: A trigger that arrives while a conversion is in progress starts nothing. It sets a sticky overrun flag, which reads as control bit 3.
- R12: Control bits 7:4 and 2:0 read back as written at offset 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| wr | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| se_mode | input | 1 | 1: sixteen single-ended channels, 0: eight differential |
| uni_mode | input | 1 | Unipolar input range strap, shown in status |
| ext_trig | input | 1 | External trigger pulse |
| pacer_tick | input | 1 | Pacer trigger pulse |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 4 | Channel being converted |
| conv_gain | output | 4 | Gain code for that channel |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | 12 | Converter sample |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | One-cycle DMA request per completion |

## Verification
The hardest case to reach from the ports is a trigger that lands inside a conversion. With a realistic converter model, the done pulse arrives quickly and leaves almost no window. The bench's converter model therefore has a hold switch that freezes its done pulse. While the switch is on, the bench issues a second software trigger. It confirms that no extra start appears and that the overrun flag is set. It then releases the converter and checks that the single pending result arrives intact.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_N   = 16,
  parameter int DATA_W = 12,
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              se_mode,
  input  logic              uni_mode,
  input  logic              ext_trig,
  input  logic              pacer_tick,
  output logic              conv_start,
  output logic [$clog2(CH_N)-1:0] conv_chan,
  output logic [GAIN_W-1:0] conv_gain,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq,
  output logic              dma_req
);
  localparam int CH_W = $clog2(CH_N);
  localparam int RES_W = DATA_W + CH_W;
  localparam logic [CH_W-1:0] FULL_M = CH_W'(CH_N - 1);
  localparam logic [CH_W-1:0] HALF_M = FULL_M >> 1;

  logic [GAIN_W-1:0] gain_q [CH_N];
  logic [CH_W-1:0] first_q, last_q, next_q, cur_q;
  logic [3:0] ctrl_hi;
  logic [2:0] ctrl_lo;
  logic [RES_W-1:0] res_q;
  logic busy, drdy, eoc, ovr;

  wire [CH_W-1:0] cmask = se_mode ? FULL_M : HALF_M;
  wire w_lo   = wr && addr == 4'd0;
  wire w_gain = wr && addr == 4'd1;
  wire w_mux  = wr && addr == 4'd2;
  wire w_stat = wr && addr == 4'd8;
  wire w_ctrl = wr && addr == 4'd9;

  wire trig = (ctrl_lo[1:0] == 2'd1 && w_lo) ||
              (ctrl_lo[1:0] == 2'd2 && ext_trig) ||
              (ctrl_lo[1:0] == 2'd3 && pacer_tick);
  wire fire = trig && !busy;
  wire done = busy && conv_done;

  wire [CH_W-1:0] now_ch = next_q & cmask;
  wire [CH_W-1:0] adv_ch = (now_ch == (last_q & cmask)) ? (first_q & cmask)
                                                         : ((now_ch + 1'b1) & cmask);

  assign conv_chan = cur_q;
  assign irq = drdy && ctrl_hi[3] && !ctrl_lo[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CH_N; i++) gain_q[i] <= '0;
    end else if (w_gain) begin
      gain_q[first_q] <= wdata[GAIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= '0;
      last_q     <= '0;
      next_q     <= '0;
      cur_q      <= '0;
      ctrl_hi    <= '0;
      ctrl_lo    <= '0;
      res_q      <= '0;
      busy       <= 1'b0;
      drdy       <= 1'b0;
      eoc        <= 1'b0;
      ovr        <= 1'b0;
      conv_start <= 1'b0;
      conv_gain  <= '0;
      dma_req    <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      dma_req    <= 1'b0;
      if (w_ctrl) begin
        ctrl_hi <= wdata[7:4];
        ctrl_lo <= wdata[2:0];
      end
      if (w_stat) begin
        drdy <= 1'b0;
        ovr  <= 1'b0;
      end
      if (trig && busy) ovr <= 1'b1;
      if (fire) begin
        busy       <= 1'b1;
        conv_start <= 1'b1;
        cur_q      <= now_ch;
        conv_gain  <= gain_q[now_ch];
        eoc        <= 1'b0;
        next_q     <= adv_ch;
      end
      if (done) begin
        busy    <= 1'b0;
        res_q   <= {conv_data, cur_q};
        eoc     <= 1'b1;
        drdy    <= 1'b1;
        dma_req <= ctrl_lo[2];
      end
      if (w_mux) begin
        first_q <= wdata[CH_W-1:0];
        last_q  <= wdata[7:4];
        next_q  <= wdata[CH_W-1:0];
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = res_q[7:0];
      4'd1:    rdata = res_q[15:8];
      4'd2:    rdata = {last_q, first_q};
      4'd8:    rdata = {eoc, uni_mode, se_mode, drdy, next_q};
      4'd9:    rdata = {ctrl_hi, ovr, ctrl_lo};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic [3:0] addr,
  input logic       se_mode,
  input logic       conv_start,
  input logic [3:0] conv_chan,
  input logic       conv_done,
  input logic       dma_req,
  input logic       busy,
  input logic       drdy
);
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(busy));

  p_diff_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !$past(se_mode)) |-> !conv_chan[3]);

  p_ready_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done) |=> drdy);

  p_ready_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 4'd8 && !(busy && conv_done)) |=> !drdy);

  p_dma_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .se_mode(se_mode),
  .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
  .dma_req(dma_req), .busy(busy), .drdy(drdy)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic se_mode = 1'b1, uni_mode = 1'b0;
  logic ext_trig = 1'b0, pacer_tick = 1'b0;
  logic conv_start, conv_done = 1'b0, irq, dma_req;
  logic [3:0] conv_chan, conv_gain;
  logic [11:0] conv_data = '0;

  int checks = 0, errors = 0, n_start = 0, n_dma = 0;
  bit finished = 0;
  bit adc_hold = 0;
  logic [3:0] exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  adc_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rdata(rdata),
    .se_mode(se_mode), .uni_mode(uni_mode), .ext_trig(ext_trig), .pacer_tick(pacer_tick),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_gain(conv_gain),
    .conv_done(conv_done), .conv_data(conv_data), .irq(irq), .dma_req(dma_req)
  );

  function automatic logic [3:0] gval(input logic [3:0] ch);
    return 4'((ch * 3 + 1) & 15);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // converter model
  logic [3:0] m_ch, m_gain;
  bit m_pend = 0;
  int m_cnt = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (m_pend && !adc_hold) begin
      if (m_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = {m_gain, m_ch, 4'hA};
        m_pend = 0;
      end else m_cnt--;
    end
    if (conv_start) begin
      m_pend = 1; m_cnt = 2; m_ch = conv_chan; m_gain = conv_gain;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dma_req) n_dma++;
    if (rst_n && conv_start) begin
      n_start++;
      if (exp_q.size() == 0) chk(0, "R4 unexpected conv_start", conv_chan, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(conv_chan == e, "R5/R7 conv_chan", conv_chan, e);
        chk(conv_gain == gval(e), "R3 conv_gain", conv_gain, gval(e));
      end
    end
  end

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic fire(input int how);
    case (how)
      1: wreg(4'd0, 8'h00);
      2: begin @(negedge clk); ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0; end
      default: begin @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0; end
    endcase
  endtask

  task automatic wait_eoc();
    logic [7:0] s;
    for (int i = 0; i < 50; i++) begin
      rreg(4'd8, s);
      if (s[7]) break;
    end
  endtask

  task automatic convert(input logic [3:0] ch, input int how);
    logic [7:0] lo, hi, st;
    logic [15:0] expw;
    rreg(4'd8, st);
    chk(st[3:0] == ch, "R5 status next channel", st[3:0], ch);
    exp_q.push_back(ch);
    fire(how);
    wait_eoc();
    rreg(4'd0, lo);
    rreg(4'd1, hi);
    expw = {gval(ch), ch, 4'hA, ch};
    chk({hi, lo} == expw, "R6 result word", {hi, lo}, expw);
  endtask

  initial begin
    #(CLK_NS * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rreg(4'd8, d); chk(d == 8'h20, "R1 status reset", d, 8'h20);
    rreg(4'd9, d); chk(d == 8'h00, "R1 control reset", d, 8'h00);
    chk(irq == 1'b0 && dma_req == 1'b0, "R1 irq/dma low", irq, 0);

    wreg(4'd9, 8'h61);
    rreg(4'd9, d); chk(d == 8'h61, "R12 control readback", d, 8'h61);

    for (int c = 0; c < 16; c++) begin
      wreg(4'd2, 8'(c));
      wreg(4'd1, {4'h0, gval(4'(c))});
    end
    wreg(4'd2, 8'h52);
    rreg(4'd2, d); chk(d == 8'h52, "R2 mux readback", d, 8'h52);
    rreg(4'd8, d); chk(d[3:0] == 4'd2, "R2 next = first", d[3:0], 2);

    convert(4'd2, 1); convert(4'd3, 1); convert(4'd4, 1);
    convert(4'd5, 1); convert(4'd2, 1); convert(4'd3, 1);

    // R4: unselected sources ignored
    s0 = n_start;
    fire(2); fire(3);
    repeat (6) @(negedge clk);
    chk(n_start == s0, "R4 ext/pacer ignored in software mode", n_start, s0);
    rreg(4'd8, d); chk(d[3:0] == 4'd4, "R4 next unchanged", d[3:0], 4);

    wreg(4'd9, 8'h62);
    convert(4'd4, 2);
    s0 = n_start;
    fire(1); fire(3);
    repeat (6) @(negedge clk);
    chk(n_start == s0, "R4 write/pacer ignored in external mode", n_start, s0);
    wreg(4'd9, 8'h63);
    convert(4'd5, 3);
    convert(4'd2, 3);
    wreg(4'd9, 8'h01);

    // R7 wrap modulo 16
    wreg(4'd2, 8'h1E);
    convert(4'd14, 1); convert(4'd15, 1); convert(4'd0, 1);
    convert(4'd1, 1); convert(4'd14, 1);

    // R7 modulo 8 in differential mode
    se_mode = 1'b0;
    wreg(4'd2, 8'h16);
    rreg(4'd8, d); chk(d[5] == 1'b0, "R1 status shows differential", d[5], 0);
    convert(4'd6, 1); convert(4'd7, 1); convert(4'd0, 1);
    convert(4'd1, 1); convert(4'd6, 1);
    se_mode = 1'b1;

    // R8 single channel
    wreg(4'd2, 8'h99);
    convert(4'd9, 1); convert(4'd9, 1); convert(4'd9, 1);

    // R9 / R11 with converter held
    adc_hold = 1;
    exp_q.push_back(4'd9);
    fire(1);
    rreg(4'd8, d); chk(d[7] == 1'b0, "R9 eoc cleared while busy", d[7], 0);
    s0 = n_start;
    fire(1);
    repeat (3) @(negedge clk);
    chk(n_start == s0, "R11 trigger while busy ignored", n_start, s0);
    rreg(4'd9, d); chk(d[3] == 1'b1, "R11 overrun sticky", d[3], 1);
    adc_hold = 0;
    wait_eoc();
    rreg(4'd8, d); chk(d[7:4] == 4'b1011, "R9 eoc and ready set", d[7:4], 4'b1011);
    rreg(4'd1, d); chk(d == {gval(4'd9), 4'd9}, "R6 held result high", d, {gval(4'd9), 4'd9});
    rreg(4'd9, d); chk(d[3] == 1'b1, "R11 overrun still set", d[3], 1);
    wreg(4'd8, 8'h00);
    rreg(4'd8, d); chk(d[7:4] == 4'b1010, "R9 ready cleared, eoc kept", d[7:4], 4'b1010);
    rreg(4'd9, d); chk(d[3] == 1'b0, "R9 overrun cleared", d[3], 0);

    // R10 interrupt mode
    wreg(4'd9, 8'h81);
    chk(irq == 1'b0, "R10 irq low before data", irq, 0);
    convert(4'd9, 1);
    chk(irq == 1'b1, "R10 irq on ready", irq, 1);
    wreg(4'd8, 8'h00);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);

    // R10 DMA mode
    wreg(4'd9, 8'h85);
    s0 = n_dma;
    convert(4'd9, 1);
    repeat (2) @(negedge clk);
    chk(n_dma == s0 + 1, "R10 one dma pulse", n_dma, s0 + 1);
    chk(irq == 1'b0, "R10 irq masked in dma mode", irq, 0);
    convert(4'd9, 1);
    repeat (2) @(negedge clk);
    chk(n_dma == s0 + 2, "R10 second dma pulse", n_dma, s0 + 2);

    chk(exp_q.size() == 0, "R5 all expected starts seen", exp_q.size(), 0);
    finish_run();
  end
endmodule